// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is a 32-bit down counter driven through a small synchronous register port of six 16-bit locations. Software writes a 32-bit reload value as two 16-bit halves, then starts or stops the counter. It selects single-shot or free-running operation and can enable an interrupt on expiry. The live count can be copied into a pair of capture registers and read back. Reading back this way does not disturb the counter.

When the count passes through zero, a sticky expiry flag is raised and the counter reloads from the stored value. The `WATCHDOG` parameter builds a variant in which each expiry also produces a one-cycle reset-request pulse. In that variant, writing a reload half refreshes the count and leaves the timer running, so software keeps the system alive by rewriting the reload value at regular intervals. Because the reload value is a whole number of clock cycles, a desired time interval is rounded to the nearest cycle count before it is programmed.

Top module: `countdown_timer`

## Requirements
- R1: After reset, status (address 0) reads 0, the reload value equals `RESET_PERIOD`, and `irq` and `resetReq` are 0.
- R2: The address map is: 0 status, 1 control, 2 reload low half, 3 reload high half, 4 capture low half, 5 capture high half. Status bit 0 is the expiry flag and bit 1 is the running flag. Control bits 0 (interrupt enable) and 1 (free-running) read back as written.
- R3: Writing control with bit 2 set starts the counter. Writing control with bit 3 set stops it, and stop wins when both bits are set. While the counter is stopped, the count holds.
- R4: Suppose a control write starts the counter at clock edge E while the count equals P. The expiry flag then rises at edge E+P+1, and the count reloads from the stored reload value at that same edge.
- R5: The expiry flag stays set until any write to status. If the counter expires in the same cycle as that write, the flag stays set.
- R6: With the free-running bit at 0, expiry clears the running flag. With it at 1, counting continues and expiry repeats every P+1 cycles.
- R7: `irq` is high exactly when the expiry flag and the interrupt-enable bit are both set.
- R8: When `WATCHDOG` is 0, a write to either reload half stops the counter and loads the count with the new reload value.
- R9: A write of any data to address 4 or 5 copies the count held before that edge into both capture halves. Counting is not affected.
- R10: When `WATCHDOG` is 1, each expiry produces a one-cycle pulse on `resetReq`. A reload write loads the count and leaves the running flag unchanged. When `WATCHDOG` is 0, `resetReq` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wrData | input | REG_W | Write data |
| rdData | output | REG_W | Read data for `addr` (combinational) |
| irq | output | 1 | Expiry interrupt |
| resetReq | output | 1 | Watchdog reset request pulse |

## Verification
Two functions can collide in the same cycle: the counter can expire on the very edge where software writes status to clear the expiry flag. The bench provokes this by starting the counter in free-running mode and counting edges from the start write. It times a status write to land on the second expiry edge, then reads status and expects the flag still set. A second status write one cycle later must clear the flag. A capture taken mid-count is likewise timed against the decrement, and must return the value held before that edge.

// File: rtl/ctimer_pkg.sv
package ctimer_pkg;

  // Register addresses; the order is the software-visible map.
  localparam logic [2:0] ADDR_STATUS  = 3'd0;
  localparam logic [2:0] ADDR_CONTROL = 3'd1;
  localparam logic [2:0] ADDR_PER_LO  = 3'd2;
  localparam logic [2:0] ADDR_PER_HI  = 3'd3;
  localparam logic [2:0] ADDR_CAP_LO  = 3'd4;
  localparam logic [2:0] ADDR_CAP_HI  = 3'd5;

  // Control-field bit positions.
  localparam int CTL_IRQ_EN = 0;
  localparam int CTL_FREE   = 1;
  localparam int CTL_START  = 2;
  localparam int CTL_STOP   = 3;

  // Strobes from control to datapath.
  typedef struct packed {
    logic dec;
    logic reload;
    logic capture;
    logic loadLo;
    logic loadHi;
  } dpStrobes_t;

endpackage

// File: rtl/ctimer_ctrl.sv
module ctimer_ctrl
  import ctimer_pkg::*;
#(
  parameter bit WATCHDOG = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [2:0] addr,
  input  logic [3:0] ctlBits,
  input  logic       isZero,
  output dpStrobes_t strobes,
  output logic       runFlag,
  output logic       toFlag,
  output logic       irqEn,
  output logic       freeRun,
  output logic       resetReq
);

  logic wrStatus, wrCtrl, wrPer, timeout, runNext;

  always_comb begin
    wrStatus = wrEn && (addr == ADDR_STATUS);
    wrCtrl   = wrEn && (addr == ADDR_CONTROL);
    wrPer    = wrEn && ((addr == ADDR_PER_LO) || (addr == ADDR_PER_HI));
    timeout  = runFlag && isZero;

    strobes.dec     = runFlag && !isZero;
    strobes.reload  = timeout || wrPer;
    strobes.capture = wrEn && ((addr == ADDR_CAP_LO) || (addr == ADDR_CAP_HI));
    strobes.loadLo  = wrEn && (addr == ADDR_PER_LO);
    strobes.loadHi  = wrEn && (addr == ADDR_PER_HI);

    runNext = runFlag;
    if (timeout && !freeRun) runNext = 1'b0;
    if (wrCtrl && ctlBits[CTL_START]) runNext = 1'b1;
    if (wrCtrl && ctlBits[CTL_STOP]) runNext = 1'b0;
    if (wrPer && !WATCHDOG) runNext = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runFlag  <= 1'b0;
      toFlag   <= 1'b0;
      irqEn    <= 1'b0;
      freeRun  <= 1'b0;
      resetReq <= 1'b0;
    end else begin
      runFlag  <= runNext;
      resetReq <= WATCHDOG && timeout;
      if (timeout) toFlag <= 1'b1;
      else if (wrStatus) toFlag <= 1'b0;
      if (wrCtrl) begin
        irqEn   <= ctlBits[CTL_IRQ_EN];
        freeRun <= ctlBits[CTL_FREE];
      end
    end
  end

endmodule

// File: rtl/ctimer_datapath.sv
module ctimer_datapath
  import ctimer_pkg::*;
#(
  parameter int REG_W = 16,
  localparam int CW = 2 * REG_W,
  parameter logic [CW-1:0] RESET_PERIOD = CW'(15)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobes_t       strobes,
  input  logic [REG_W-1:0] wrData,
  output logic             isZero,
  output logic [CW-1:0]    periodVal,
  output logic [CW-1:0]    countVal,
  output logic [CW-1:0]    snapVal
);

  logic [CW-1:0] periodNext;

  always_comb begin
    periodNext = periodVal;
    if (strobes.loadLo) periodNext[REG_W-1:0] = wrData;
    if (strobes.loadHi) periodNext[CW-1:REG_W] = wrData;
    isZero = (countVal == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodVal <= RESET_PERIOD;
      countVal  <= RESET_PERIOD;
      snapVal   <= '0;
    end else begin
      periodVal <= periodNext;
      if (strobes.reload) countVal <= periodNext;
      else if (strobes.dec) countVal <= countVal - 1'b1;
      if (strobes.capture) snapVal <= countVal;
    end
  end

endmodule

// File: rtl/countdown_timer.sv
module countdown_timer
  import ctimer_pkg::*;
#(
  parameter int REG_W = 16,
  parameter bit WATCHDOG = 1'b0,
  parameter logic [2*REG_W-1:0] RESET_PERIOD = (2*REG_W)'(15)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       addr,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             irq,
  output logic             resetReq
);

  localparam int CW = 2 * REG_W;

  dpStrobes_t    strobes;
  logic          runFlag, toFlag, irqEn, freeRun, isZero;
  logic [CW-1:0] periodVal, countVal, snapVal;

  ctimer_ctrl #(.WATCHDOG(WATCHDOG)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .ctlBits(wrData[3:0]),
    .isZero(isZero), .strobes(strobes), .runFlag(runFlag), .toFlag(toFlag),
    .irqEn(irqEn), .freeRun(freeRun), .resetReq(resetReq)
  );

  ctimer_datapath #(.REG_W(REG_W), .RESET_PERIOD(RESET_PERIOD)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .isZero(isZero), .periodVal(periodVal), .countVal(countVal), .snapVal(snapVal)
  );

  always_comb begin
    irq = toFlag && irqEn;
    unique case (addr)
      ADDR_STATUS:  rdData = REG_W'({runFlag, toFlag});
      ADDR_CONTROL: rdData = REG_W'({freeRun, irqEn});
      ADDR_PER_LO:  rdData = periodVal[REG_W-1:0];
      ADDR_PER_HI:  rdData = periodVal[CW-1:REG_W];
      ADDR_CAP_LO:  rdData = snapVal[REG_W-1:0];
      ADDR_CAP_HI:  rdData = snapVal[CW-1:REG_W];
      default:      rdData = '0;
    endcase
  end

endmodule

// File: rtl/countdown_timer_chk.sv
module countdown_timer_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          wrEn,
  input logic [2:0]    addr,
  input logic          stopBit,
  input logic          runFlag,
  input logic          toFlag,
  input logic          freeRun,
  input logic          isZero,
  input logic          irq,
  input logic          resetReq,
  input logic [CW-1:0] countVal
);

  logic perWr, ctlWr, stsWr;
  always_comb begin
    perWr = wrEn && (addr == 3'd2 || addr == 3'd3);
    ctlWr = wrEn && (addr == 3'd1);
    stsWr = wrEn && (addr == 3'd0);
  end

  AST_TO_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(toFlag) |-> $past(runFlag && isZero)); // R4
  AST_TO_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (runFlag && isZero) |=> toFlag); // R5
  AST_TO_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (toFlag && !stsWr) |=> toFlag); // R5
  AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rstN)
    (runFlag && isZero && !freeRun && !ctlWr && !perWr) |=> !runFlag); // R6
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && stopBit) |=> !runFlag); // R3
  AST_FROZEN_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (!runFlag && !perWr) |=> $stable(countVal)); // R3
  AST_IRQ_NEEDS_TO: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> toFlag); // R7
  AST_RESETREQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> $past(runFlag && isZero)); // R10

endmodule

bind countdown_timer countdown_timer_chk #(.CW(2*REG_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .stopBit(wrData[3]),
  .runFlag(runFlag), .toFlag(toFlag), .freeRun(freeRun), .isZero(isZero),
  .irq(irq), .resetReq(resetReq), .countVal(countVal)
);

// File: tb/tb_countdown_timer.sv
module tb_countdown_timer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, wrEn2 = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wrData = 16'd0;
  logic [15:0] rdData, rdData2;
  logic        irq, resetReq, irq2, resetReq2;
  int          checks = 0, errors = 0;

  always #4 clk = ~clk; // 125 MHz

  countdown_timer #(.REG_W(16), .WATCHDOG(1'b0)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irq(irq), .resetReq(resetReq));

  countdown_timer #(.REG_W(16), .WATCHDOG(1'b1)) wdog (
    .clk(clk), .rstN(rstN), .wrEn(wrEn2), .addr(addr), .wrData(wrData),
    .rdData(rdData2), .irq(irq2), .resetReq(resetReq2));

  // {isRead, addr, data, expected}
  localparam int NV = 12;
  localparam logic [35:0] VEC [NV] = '{
    {1'b1, 3'd0, 16'h0000, 16'h0000},
    {1'b1, 3'd2, 16'h0000, 16'h000F},
    {1'b1, 3'd3, 16'h0000, 16'h0000},
    {1'b0, 3'd2, 16'h1234, 16'h0000},
    {1'b1, 3'd2, 16'h0000, 16'h1234},
    {1'b0, 3'd3, 16'h0001, 16'h0000},
    {1'b1, 3'd3, 16'h0000, 16'h0001},
    {1'b0, 3'd1, 16'h0003, 16'h0000},
    {1'b1, 3'd1, 16'h0000, 16'h0003},
    {1'b0, 3'd5, 16'hBEEF, 16'h0000},
    {1'b1, 3'd4, 16'h0000, 16'h1234},
    {1'b1, 3'd5, 16'h0000, 16'h0001}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(bit sel, logic [2:0] a, logic [15:0] d);
    addr = a; wrData = d;
    if (sel) wrEn2 = 1'b1; else wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrEn2 = 1'b0;
  endtask

  task automatic readReg(bit sel, logic [2:0] a, output logic [15:0] v);
    addr = a;
    #1;
    v = sel ? rdData2 : rdData;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    logic [15:0] v;
    bit          bad;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 resetReq", 32'(resetReq), 0);
    chk("R1 wdog resetReq", 32'(resetReq2), 0);

    // R2 register map walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][35]) begin
        readReg(0, VEC[i][34:32], v);
        chk($sformatf("R2 vec%0d", i), 32'(v), 32'(VEC[i][15:0]));
      end else begin
        regWrite(0, VEC[i][34:32], VEC[i][31:16]);
      end
    end

    // R4/R6/R7 single-shot timing, period 5
    regWrite(0, 3'd2, 16'd5);
    regWrite(0, 3'd3, 16'd0);
    regWrite(0, 3'd1, 16'h0005);           // irq enable + start, edge E0
    readReg(0, 3'd0, v); chk("R3 start sets run", 32'(v), 2);
    repeat (5) @(negedge clk);
    readReg(0, 3'd0, v); chk("R4 no expiry at E5", 32'(v), 2);
    chk("R7 irq low before expiry", 32'(irq), 0);
    @(negedge clk);
    readReg(0, 3'd0, v); chk("R6 one-shot expiry E6", 32'(v), 1);
    chk("R7 irq high", 32'(irq), 1);
    chk("R10 no resetReq when WATCHDOG=0", 32'(resetReq), 0);
    regWrite(0, 3'd4, 16'd0);
    readReg(0, 3'd4, v); chk("R4 reload to period", 32'(v), 5);
    repeat (8) @(negedge clk);
    readReg(0, 3'd0, v); chk("R5 flag sticky", 32'(v), 1);
    regWrite(0, 3'd0, 16'd0);
    readReg(0, 3'd0, v); chk("R5 status write clears", 32'(v), 0);
    chk("R7 irq low after clear", 32'(irq), 0);

    // R9 capture while running, R6 free-running, R5 collision
    regWrite(0, 3'd1, 16'h0006);           // free + start, E0
    @(negedge clk);
    regWrite(0, 3'd4, 16'd0);              // capture at E2
    readReg(0, 3'd4, v); chk("R9 capture pre-edge count", 32'(v), 4);
    repeat (4) @(negedge clk);             // n6
    readReg(0, 3'd0, v); chk("R6 free-run keeps running", 32'(v), 3);
    chk("R7 irq masked", 32'(irq), 0);
    repeat (5) @(negedge clk);             // n11
    regWrite(0, 3'd0, 16'd0);              // clear lands on E12 expiry
    readReg(0, 3'd0, v); chk("R5 expiry beats clear", 32'(v), 3);
    regWrite(0, 3'd0, 16'd0);              // E13
    readReg(0, 3'd0, v); chk("R5 clear next cycle", 32'(v), 2);
    regWrite(0, 3'd1, 16'h0003);           // E14, enable irq, no start
    chk("R7 irq low flag clear", 32'(irq), 0);
    repeat (4) @(negedge clk);             // n18
    chk("R7 irq on next expiry", 32'(irq), 1);

    // R3 stop freezes count
    regWrite(0, 3'd1, 16'h0008);           // E19 stop
    regWrite(0, 3'd4, 16'd0);
    readReg(0, 3'd4, v); chk("R3 stopped count", 32'(v), 4);
    repeat (3) @(negedge clk);
    regWrite(0, 3'd4, 16'd0);
    readReg(0, 3'd4, v); chk("R3 count holds", 32'(v), 4);
    regWrite(0, 3'd1, 16'h000C);
    readReg(0, 3'd0, v); chk("R3 stop wins over start", 32'(v), 1);

    // R8 reload write stops and loads
    regWrite(0, 3'd0, 16'd0);
    regWrite(0, 3'd1, 16'h0004);
    readReg(0, 3'd0, v); chk("R8 running before", 32'(v), 2);
    regWrite(0, 3'd2, 16'd7);
    readReg(0, 3'd0, v); chk("R8 reload write stops", 32'(v), 0);
    regWrite(0, 3'd4, 16'd0);
    readReg(0, 3'd4, v); chk("R8 count loaded", 32'(v), 7);

    // R10 watchdog kicks and expiry pulse
    regWrite(1, 3'd2, 16'd3);
    regWrite(1, 3'd3, 16'd0);
    regWrite(1, 3'd1, 16'h0006);
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (resetReq2) bad = 1;
      regWrite(1, 3'd2, 16'd3);
      if (resetReq2) bad = 1;
    end
    chk("R10 kicks hold off resetReq", 32'(bad), 0);
    readReg(1, 3'd0, v); chk("R10 kick keeps running", 32'(v), 2);
    repeat (3) @(negedge clk);
    chk("R10 no pulse early", 32'(resetReq2), 0);
    @(negedge clk);
    chk("R10 pulse on expiry", 32'(resetReq2), 1);
    @(negedge clk);
    chk("R10 pulse one cycle", 32'(resetReq2), 0);

    finishRun();
  end

endmodule